// File: doc/BRIEF.md
# Privileged Control Register File with Trap Stack

This block holds the privileged and hyper-privileged control state of one processor strand: processor state, hyper state, trap level, interrupt level, the two trap base addresses, a small per-trap-level stack of saved trap context, eight scratch registers, the memory-management context and partition registers, a load/store-unit control word and a floating-point status word. Everything is reached through a single access port that carries a 6-bit register number, a write flag and 64-bit write data; one access may start every cycle.

Each access is answered one cycle later with a response strobe, the read data and an error flag. Writes pass through per-register masks and clamps. One read-only number returns a packed word that gathers fields from several registers for the translation unit. A request output signals the condition "trap level returned to zero while not in hyper-privileged mode with the zero-level trap enabled"; it is re-evaluated on every trap-level write.

Top module: `priv_ctl_regfile`

## Requirements
- R1: After reset the hyper state reads 0x800, the strand status reads 0x50000, every other register reads 0, and resp_o, acc_err_o, rd_data_o and tlz_req_o are 0.
- R2: An access presented with acc_valid_i is answered on the next cycle with resp_o high; a read returns the value held before the access, a write takes effect so that a read in the following cycle sees it, and a write answers with rd_data_o = 0. Register numbers: 0 processor state, 1 hyper state, 2 trap level, 3 interrupt level, 4 trap base, 5 hyper trap base, 6 saved PC, 7 saved next PC, 8 saved state, 9 saved trap type, 10 saved hyper state, 11 FP status, 12 strand status, 13 primary context, 14 secondary context, 15 partition id, 16 LSU control, 17 packed translation word, 24..31 scratch 0..7; interrupt level keeps the low 4 bits and both contexts keep the low 16 bits of a write.
- R3: A write to number 0 keeps only bits 1..4, 6..9 and 12 (mask 0x13DE); other bits read back as 0.
- R4: A write to number 4 clears bits 14..0 of the stored value; number 5 stores the full value.
- R5: Numbers 6..10 access the stack entry at index TL-1, with five independent words per level for TL = 1..6.
- R6: A trap-level write of a value above 6 stores 6; values 0..6 are stored unchanged.
- R7: An access to numbers 6..10 while TL = 0 is an error and changes no state.
- R8: A read of number 11 returns the stored value with bits 1:0 forced to 1.
- R9: Number 17 reads as: bit0 = hyper state bit 2, bit1 = hyper state bit 5, bits 3:2 = processor state bits 3:2, bits 5:4 = LSU control bits 3:2, bits 15:8 = partition id bits 7:0, bits 18:16 = TL, bits 47:32 = primary context, bits 63:48 = secondary context, other bits 0; writing it is an error.
- R10: On every accepted trap-level write, tlz_req_o becomes 1 if hyper state bit 0 is 1, the new TL is 0 and hyper state bit 2 is 0, and becomes 0 otherwise; other writes leave it unchanged.
- R11: An access to numbers 18..23 or 32..63 raises acc_err_o for exactly one cycle with rd_data_o = 0 and changes no state.
- R12: Numbers 24..31 are eight independent 64-bit scratch registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| acc_valid_i | input | 1 | Access request this cycle |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_num_i | input | 6 | Register number |
| acc_wdata_i | input | 64 | Write data |
| resp_o | output | 1 | Response strobe, one cycle after an access |
| rd_data_o | output | 64 | Read data of the answered access |
| acc_err_o | output | 1 | Answered access was refused |
| tlz_req_o | output | 1 | Trap-level-zero interrupt request |

## Verification
The hardest state to reach from the port is the trap stack at depth: every stacked word is only addressable once the trap level has been programmed, so the stimulus writes each level from 1 to 6 in turn, fills the five words there, and then walks back over all levels reading them to show no level aliases another. The zero-level request needs a precise ordering of hyper-state writes and trap-level writes; the bench sweeps both relevant hyper-state bits against trap levels zero and non-zero and also checks that a hyper-state write alone leaves the request untouched.

// File: rtl/pcr_pkg.sv
`timescale 1ns/1ps
package pcr_pkg;
  localparam int XLEN   = 64;
  localparam int NUM_W  = 6;
  localparam int CTX_W  = 16;
  localparam int IRQ_W  = 4;
  localparam int NUM_TF = 5;

  typedef enum logic [4:0] {
    RID_PSTAT, RID_HSTAT, RID_TLVL, RID_IRQLVL, RID_TBASE, RID_HTBASE,
    RID_TPC, RID_TNPC, RID_TSTAT, RID_TTYPE, RID_HTSTAT,
    RID_FPST, RID_STRAND, RID_CTXP, RID_CTXS, RID_PART, RID_LSU,
    RID_TLBW, RID_SCR, RID_NONE
  } reg_id_e;

  typedef enum logic [2:0] {
    TF_PC, TF_NPC, TF_STATE, TF_TYPE, TF_HSTATE
  } trap_fld_e;

  localparam logic [XLEN-1:0] PSTAT_KEEP = 64'h0000_0000_0000_13DE;
  localparam logic [XLEN-1:0] TBASE_KEEP = ~64'h0000_0000_0000_7FFF;
  localparam logic [XLEN-1:0] HSTAT_RST  = 64'h0000_0000_0000_0800;
  localparam logic [XLEN-1:0] STRAND_RST = 64'h0000_0000_0005_0000;
  localparam logic [XLEN-1:0] FP_FORCE   = 64'h0000_0000_0000_0003;

  localparam int HS_TLZ   = 0;
  localparam int HS_HPRIV = 2;
  localparam int HS_RED   = 5;

  // Packed word handed to the translation unit.
  function automatic logic [XLEN-1:0] pack_tlb(
    input logic [XLEN-1:0]  hs,
    input logic [XLEN-1:0]  ps,
    input logic [XLEN-1:0]  lsu,
    input logic [XLEN-1:0]  part,
    input logic [2:0]       tl,
    input logic [CTX_W-1:0] cp,
    input logic [CTX_W-1:0] cs
  );
    return {cs, cp, 13'b0, tl, part[7:0], 2'b0, lsu[3:2], ps[3:2],
            hs[HS_RED], hs[HS_HPRIV]};
  endfunction
endpackage

// File: rtl/pcr_decode.sv
`timescale 1ns/1ps
module pcr_decode
  import pcr_pkg::*;
#(
  parameter int NUM_SCR  = 8,
  parameter int SCR_BASE = 24,
  parameter int SCR_IW   = $clog2(NUM_SCR)
) (
  input  logic [NUM_W-1:0]  num_i,
  output reg_id_e           id_o,
  output trap_fld_e         fld_o,
  output logic              is_trap_o,
  output logic              is_ro_o,
  output logic [SCR_IW-1:0] scr_idx_o
);
  logic [NUM_W-1:0] scr_off;

  always_comb begin
    scr_off   = num_i - NUM_W'(SCR_BASE);
    scr_idx_o = scr_off[SCR_IW-1:0];
    fld_o     = TF_PC;
    if (int'(num_i) >= SCR_BASE && int'(num_i) < SCR_BASE + NUM_SCR) begin
      id_o = RID_SCR;
    end else begin
      case (num_i)
        6'd0:    id_o = RID_PSTAT;
        6'd1:    id_o = RID_HSTAT;
        6'd2:    id_o = RID_TLVL;
        6'd3:    id_o = RID_IRQLVL;
        6'd4:    id_o = RID_TBASE;
        6'd5:    id_o = RID_HTBASE;
        6'd6:    id_o = RID_TPC;
        6'd7:    id_o = RID_TNPC;
        6'd8:    id_o = RID_TSTAT;
        6'd9:    id_o = RID_TTYPE;
        6'd10:   id_o = RID_HTSTAT;
        6'd11:   id_o = RID_FPST;
        6'd12:   id_o = RID_STRAND;
        6'd13:   id_o = RID_CTXP;
        6'd14:   id_o = RID_CTXS;
        6'd15:   id_o = RID_PART;
        6'd16:   id_o = RID_LSU;
        6'd17:   id_o = RID_TLBW;
        default: id_o = RID_NONE;
      endcase
    end
    case (id_o)
      RID_TNPC:   fld_o = TF_NPC;
      RID_TSTAT:  fld_o = TF_STATE;
      RID_TTYPE:  fld_o = TF_TYPE;
      RID_HTSTAT: fld_o = TF_HSTATE;
      default:    fld_o = TF_PC;
    endcase
    is_trap_o = (id_o == RID_TPC) || (id_o == RID_TNPC) || (id_o == RID_TSTAT) ||
                (id_o == RID_TTYPE) || (id_o == RID_HTSTAT);
    is_ro_o   = (id_o == RID_TLBW);
  end
endmodule

// File: rtl/pcr_trap_stack.sv
`timescale 1ns/1ps
module pcr_trap_stack
  import pcr_pkg::*;
#(
  parameter int MAX_TL = 6,
  parameter int LVL_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  trap_fld_e        fld_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  rdata_o
);
  logic [NUM_TF-1:0][XLEN-1:0] lvl_view [MAX_TL];

  for (genvar g = 0; g < MAX_TL; g++) begin : gen_lvl
    logic [NUM_TF-1:0][XLEN-1:0] slot_q;
    logic [NUM_TF-1:0]           slot_en;

    always_comb begin
      for (int f = 0; f < NUM_TF; f++) begin
        slot_en[f] = wr_en_i && (lvl_i == LVL_W'(g)) && (int'(fld_i) == f);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else begin
        for (int f = 0; f < NUM_TF; f++) begin
          if (slot_en[f]) slot_q[f] <= wdata_i;
        end
      end
    end

    assign lvl_view[g] = slot_q;
  end

  always_comb begin
    rdata_o = '0;
    if (int'(lvl_i) < MAX_TL && int'(fld_i) < NUM_TF) begin
      rdata_o = lvl_view[lvl_i][fld_i];
    end
  end

  // R5
  lvl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |-> (int'(lvl_i) < MAX_TL));
endmodule

// File: rtl/pcr_scratch.sv
`timescale 1ns/1ps
module pcr_scratch
  import pcr_pkg::*;
#(
  parameter int NUM_SCR = 8,
  parameter int IDX_W   = $clog2(NUM_SCR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [XLEN-1:0]  wdata_i,
  output logic [XLEN-1:0]  rdata_o
);
  logic [XLEN-1:0] scr_view [NUM_SCR];

  for (genvar s = 0; s < NUM_SCR; s++) begin : gen_scr
    logic [XLEN-1:0] val_q;
    logic            val_en;

    assign val_en = wr_en_i && (idx_i == IDX_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      val_q <= '0;
      else if (val_en) val_q <= wdata_i;
    end

    assign scr_view[s] = val_q;
  end

  always_comb begin
    rdata_o = '0;
    if (int'(idx_i) < NUM_SCR) rdata_o = scr_view[idx_i];
  end
endmodule

// File: rtl/priv_ctl_regfile.sv
`timescale 1ns/1ps
module priv_ctl_regfile
  import pcr_pkg::*;
#(
  parameter int MAX_TL   = 6,
  parameter int NUM_SCR  = 8,
  parameter int SCR_BASE = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid_i,
  input  logic             acc_write_i,
  input  logic [5:0]       acc_num_i,
  input  logic [63:0]      acc_wdata_i,
  output logic             resp_o,
  output logic [63:0]      rd_data_o,
  output logic             acc_err_o,
  output logic             tlz_req_o
);
  localparam int TLW    = $clog2(MAX_TL + 1);
  localparam int SCR_IW = $clog2(NUM_SCR);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Decode
  reg_id_e           rid;
  trap_fld_e         tfld;
  logic              is_trap, is_ro;
  logic [SCR_IW-1:0] scr_idx;

  pcr_decode #(.NUM_SCR(NUM_SCR), .SCR_BASE(SCR_BASE), .SCR_IW(SCR_IW)) u_dec (
    .num_i     (acc_num_i),
    .id_o      (rid),
    .fld_o     (tfld),
    .is_trap_o (is_trap),
    .is_ro_o   (is_ro),
    .scr_idx_o (scr_idx)
  );

  // State
  logic [XLEN-1:0]  pstat_q, hstat_q, tbase_q, htbase_q, fp_q, strand_q, part_q, lsu_q;
  logic [TLW-1:0]   tl_q;
  logic [IRQ_W-1:0] pil_q;
  logic [CTX_W-1:0] ctxp_q, ctxs_q;
  logic             tlz_q, resp_q, err_q;
  logic [XLEN-1:0]  rdat_q;

  // Next-state
  logic             err_c, wr_ok;
  logic             we_pstat, we_hstat, we_tl, we_pil, we_tbase, we_htbase;
  logic             we_fp, we_strand, we_ctxp, we_ctxs, we_part, we_lsu;
  logic             we_trap, we_scr;
  logic [XLEN-1:0]  pstat_d, tbase_d;
  logic [TLW-1:0]   tl_d, trap_lvl;
  logic             tlz_d;
  logic [XLEN-1:0]  trap_rd, scr_rd, rd_mux, rdat_d;

  always_comb begin
    err_c = acc_valid_i &&
            ((rid == RID_NONE) || (acc_write_i && is_ro) ||
             (is_trap && (tl_q == '0)));
    wr_ok = acc_valid_i && acc_write_i && !err_c;

    we_pstat  = wr_ok && (rid == RID_PSTAT);
    we_hstat  = wr_ok && (rid == RID_HSTAT);
    we_tl     = wr_ok && (rid == RID_TLVL);
    we_pil    = wr_ok && (rid == RID_IRQLVL);
    we_tbase  = wr_ok && (rid == RID_TBASE);
    we_htbase = wr_ok && (rid == RID_HTBASE);
    we_fp     = wr_ok && (rid == RID_FPST);
    we_strand = wr_ok && (rid == RID_STRAND);
    we_ctxp   = wr_ok && (rid == RID_CTXP);
    we_ctxs   = wr_ok && (rid == RID_CTXS);
    we_part   = wr_ok && (rid == RID_PART);
    we_lsu    = wr_ok && (rid == RID_LSU);
    we_trap   = wr_ok && is_trap;
    we_scr    = wr_ok && (rid == RID_SCR);

    pstat_d = acc_wdata_i & PSTAT_KEEP;
    tbase_d = acc_wdata_i & TBASE_KEEP;
    tl_d    = (acc_wdata_i > XLEN'(MAX_TL)) ? TLW'(MAX_TL) : acc_wdata_i[TLW-1:0];
    tlz_d   = hstat_q[HS_TLZ] && (tl_d == '0) && !hstat_q[HS_HPRIV];

    trap_lvl = tl_q - TLW'(1);
  end

  pcr_trap_stack #(.MAX_TL(MAX_TL), .LVL_W(TLW)) u_trap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en_i (we_trap),
    .lvl_i   (trap_lvl),
    .fld_i   (tfld),
    .wdata_i (acc_wdata_i),
    .rdata_o (trap_rd)
  );

  pcr_scratch #(.NUM_SCR(NUM_SCR), .IDX_W(SCR_IW)) u_scr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en_i (we_scr),
    .idx_i   (scr_idx),
    .wdata_i (acc_wdata_i),
    .rdata_o (scr_rd)
  );

  // Read selection
  always_comb begin
    case (rid)
      RID_PSTAT:  rd_mux = pstat_q;
      RID_HSTAT:  rd_mux = hstat_q;
      RID_TLVL:   rd_mux = XLEN'(tl_q);
      RID_IRQLVL: rd_mux = XLEN'(pil_q);
      RID_TBASE:  rd_mux = tbase_q;
      RID_HTBASE: rd_mux = htbase_q;
      RID_TPC, RID_TNPC, RID_TSTAT, RID_TTYPE, RID_HTSTAT:
                  rd_mux = trap_rd;
      RID_FPST:   rd_mux = fp_q | FP_FORCE;
      RID_STRAND: rd_mux = strand_q;
      RID_CTXP:   rd_mux = XLEN'(ctxp_q);
      RID_CTXS:   rd_mux = XLEN'(ctxs_q);
      RID_PART:   rd_mux = part_q;
      RID_LSU:    rd_mux = lsu_q;
      RID_TLBW:   rd_mux = pack_tlb(hstat_q, pstat_q, lsu_q, part_q, 3'(tl_q),
                                    ctxp_q, ctxs_q);
      RID_SCR:    rd_mux = scr_rd;
      default:    rd_mux = '0;
    endcase
    rdat_d = (acc_valid_i && !acc_write_i && !err_c) ? rd_mux : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pstat_q  <= '0;
      hstat_q  <= HSTAT_RST;
      tl_q     <= '0;
      pil_q    <= '0;
      tbase_q  <= '0;
      htbase_q <= '0;
      fp_q     <= '0;
      strand_q <= STRAND_RST;
      ctxp_q   <= '0;
      ctxs_q   <= '0;
      part_q   <= '0;
      lsu_q    <= '0;
      tlz_q    <= 1'b0;
      resp_q   <= 1'b0;
      err_q    <= 1'b0;
      rdat_q   <= '0;
    end else begin
      if (we_pstat)  pstat_q  <= pstat_d;
      if (we_hstat)  hstat_q  <= acc_wdata_i;
      if (we_tl)     tl_q     <= tl_d;
      if (we_tl)     tlz_q    <= tlz_d;
      if (we_pil)    pil_q    <= acc_wdata_i[IRQ_W-1:0];
      if (we_tbase)  tbase_q  <= tbase_d;
      if (we_htbase) htbase_q <= acc_wdata_i;
      if (we_fp)     fp_q     <= acc_wdata_i;
      if (we_strand) strand_q <= acc_wdata_i;
      if (we_ctxp)   ctxp_q   <= acc_wdata_i[CTX_W-1:0];
      if (we_ctxs)   ctxs_q   <= acc_wdata_i[CTX_W-1:0];
      if (we_part)   part_q   <= acc_wdata_i;
      if (we_lsu)    lsu_q    <= acc_wdata_i;
      resp_q <= acc_valid_i;
      err_q  <= err_c;
      rdat_q <= rdat_d;
    end
  end

  assign resp_o    = resp_q;
  assign rd_data_o = rdat_q;
  assign acc_err_o = err_q;
  assign tlz_req_o = tlz_q;

  // R3
  pstat_mask_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (pstat_q & ~PSTAT_KEEP) == '0);

  // R4
  tbase_low_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tbase_q[14:0] == 15'd0);

  // R6
  tl_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    int'(tl_q) <= MAX_TL);

  // R10
  tlz_raise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid_i && acc_write_i && !err_c && (acc_num_i == 6'd2) &&
     (acc_wdata_i == '0) && hstat_q[HS_TLZ] && !hstat_q[HS_HPRIV]) |=> tlz_req_o);

  // R10
  tlz_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(acc_valid_i && acc_write_i && (acc_num_i == 6'd2)) |=> $stable(tlz_req_o));

  // R11
  err_nochg_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    err_c |=> ($stable(tl_q) && $stable(pstat_q) && $stable(hstat_q) &&
               $stable(tbase_q) && acc_err_o && (rd_data_o == '0)));
endmodule

// File: tb/priv_ctl_regfile_tb.sv
`timescale 1ns/1ps
module priv_ctl_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [5:0]  acc_num = '0;
  logic [63:0] acc_wdata = '0;
  logic        resp, err, tlz;
  logic [63:0] rdat;

  always #2.5 clk = ~clk;

  priv_ctl_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid), .acc_write_i(acc_write),
    .acc_num_i(acc_num), .acc_wdata_i(acc_wdata), .resp_o(resp),
    .rd_data_o(rdat), .acc_err_o(err), .tlz_req_o(tlz)
  );

  // Bench-side model built from the requirements
  logic [63:0] m_ps, m_hs, m_tb, m_htb, m_fp, m_st, m_part, m_lsu;
  logic [3:0]  m_pil;
  logic [2:0]  m_tl;
  logic [15:0] m_cp, m_cs;
  logic [63:0] m_tr [6][5];
  logic [63:0] m_scr [8];
  logic        m_tlz;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  function automatic string tag_of(input int n);
    if (n == 0) return "R3";
    if (n == 4 || n == 5) return "R4";
    if (n == 2) return "R6";
    if (n >= 6 && n <= 10) return (m_tl == 0) ? "R7" : "R5";
    if (n == 11) return "R8";
    if (n == 17) return "R9";
    if (n >= 24 && n <= 31) return "R12";
    if ((n >= 18 && n <= 23) || n > 31) return "R11";
    return "R2";
  endfunction

  function automatic void exp_rd(input int n, output logic e, output logic [63:0] d);
    e = 1'b0; d = '0;
    case (n)
      0: d = m_ps;   1: d = m_hs;   2: d = 64'(m_tl); 3: d = 64'(m_pil);
      4: d = m_tb;   5: d = m_htb;
      6, 7, 8, 9, 10: if (m_tl == 0) e = 1'b1; else d = m_tr[m_tl-1][n-6];
      11: d = m_fp | 64'h3;
      12: d = m_st;  13: d = 64'(m_cp); 14: d = 64'(m_cs);
      15: d = m_part; 16: d = m_lsu;
      17: d = {m_cs, m_cp, 13'b0, m_tl, m_part[7:0], 2'b0, m_lsu[3:2],
               m_ps[3:2], m_hs[5], m_hs[2]};
      default: if (n >= 24 && n <= 31) d = m_scr[n-24]; else e = 1'b1;
    endcase
  endfunction

  function automatic logic exp_wr_err(input int n);
    if (n == 17 || (n >= 18 && n <= 23) || n > 31) return 1'b1;
    if (n >= 6 && n <= 10 && m_tl == 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_write(input int n, input logic [63:0] v);
    case (n)
      0: m_ps = v & 64'h13DE;
      1: m_hs = v;
      2: begin
           m_tl  = (v > 64'd6) ? 3'd6 : v[2:0];
           m_tlz = m_hs[0] && (m_tl == 0) && !m_hs[2];
         end
      3: m_pil = v[3:0];
      4: m_tb = v & ~64'h7FFF;
      5: m_htb = v;
      6, 7, 8, 9, 10: m_tr[m_tl-1][n-6] = v;
      11: m_fp = v;  12: m_st = v; 13: m_cp = v[15:0]; 14: m_cs = v[15:0];
      15: m_part = v; 16: m_lsu = v;
      default: if (n >= 24 && n <= 31) m_scr[n-24] = v;
    endcase
  endtask

  task automatic fail_line(input string tag, input string what,
                           input logic [63:0] got, input logic [63:0] exp);
    n_fail++;
    $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
  endtask

  // One access; response sampled at the next falling edge (R2).
  task automatic acc(input bit wr, input int n, input logic [63:0] v);
    logic        e_exp;
    logic [63:0] d_exp;
    string       tag;
    tag = tag_of(n);
    if (wr) begin e_exp = exp_wr_err(n); d_exp = '0; end
    else exp_rd(n, e_exp, d_exp);
    acc_valid = 1'b1; acc_write = wr; acc_num = 6'(n); acc_wdata = v;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
    n_chk++;
    if (resp !== 1'b1 || err !== e_exp || rdat !== d_exp)
      fail_line(tag, $sformatf("num=%0d wr=%0d resp=%0b err=%0b/%0b", n, wr, resp, err, e_exp),
                rdat, d_exp);
    if (wr && !e_exp) model_write(n, v);
  endtask

  task automatic chk_tlz(input string tag);
    n_chk++;
    if (tlz !== m_tlz) fail_line(tag, "tlz_req", 64'(tlz), 64'(m_tlz));
  endtask

  task automatic idle_chk(input string tag);
    @(negedge clk);
    n_chk++;
    if (resp !== 1'b0 || err !== 1'b0)
      fail_line(tag, "idle resp/err", {62'b0, resp, err}, 64'd0);
  endtask

  task automatic read_all();
    for (int n = 0; n < 64; n++) acc(1'b0, n, '0);
  endtask

  function automatic logic [63:0] pat(input int n, input int k);
    return (64'h9E37_79B9_7F4A_7C15 * 64'(n + 1 + 7 * k)) ^ (k[0] ? 64'hFFFF_0000_FFFF_0000 : 64'h0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_ps = '0; m_hs = 64'h800; m_tb = '0; m_htb = '0; m_fp = '0; m_st = 64'h50000;
    m_part = '0; m_lsu = '0; m_pil = '0; m_tl = '0; m_cp = '0; m_cs = '0; m_tlz = 1'b0;
    for (int l = 0; l < 6; l++) for (int f = 0; f < 5; f++) m_tr[l][f] = '0;
    for (int s = 0; s < 8; s++) m_scr[s] = '0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: outputs at rest after reset
    n_chk++;
    if (resp !== 1'b0 || err !== 1'b0 || tlz !== 1'b0 || rdat !== '0)
      fail_line("R1", "reset outputs", rdat, 64'd0);

    // R1 / R7 / R11: every number read in reset state
    read_all();
    idle_chk("R11");

    // Two write patterns over the whole number space, each followed by a read sweep
    for (int k = 0; k < 2; k++) begin
      for (int n = 0; n < 64; n++) acc(1'b1, n, pat(n, k));
      read_all();
    end

    // R5: fill every trap level, then read every level back
    for (int l = 1; l <= 6; l++) begin
      acc(1'b1, 2, 64'(l));
      for (int f = 0; f < 5; f++) acc(1'b1, 6 + f, pat(l * 5 + f, 3));
    end
    for (int l = 1; l <= 6; l++) begin
      acc(1'b1, 2, 64'(l));
      for (int f = 0; f < 5; f++) acc(1'b0, 6 + f, '0);
    end

    // R6: clamp of trap level
    acc(1'b1, 2, 64'd7);          acc(1'b0, 2, '0);
    acc(1'b1, 2, 64'd63);         acc(1'b0, 2, '0);
    acc(1'b1, 2, 64'hFFFF_FFFF_FFFF_FFF0); acc(1'b0, 2, '0);
    acc(1'b1, 2, 64'd6);          acc(1'b0, 2, '0);

    // R3 / R4 / R8 / R9 focused patterns
    acc(1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF); acc(1'b0, 0, '0);
    acc(1'b1, 4, 64'hFFFF_FFFF_FFFF_FFFF); acc(1'b0, 4, '0);
    acc(1'b1, 11, 64'h0);                  acc(1'b0, 11, '0);
    acc(1'b1, 16, 64'hC);  acc(1'b1, 15, 64'h1_A5);
    acc(1'b1, 13, 64'hBEEF_1234); acc(1'b1, 14, 64'h5678);
    acc(1'b1, 1, 64'h24);  acc(1'b0, 17, '0);
    acc(1'b1, 17, 64'h1);  acc(1'b0, 17, '0);

    // R10: hyper bits (tlz = bit0, hpriv = bit2) against trap levels
    for (int h = 0; h < 4; h++) begin
      acc(1'b1, 1, {56'h0, 5'b0, h[1], 1'b0, h[0]} | 64'h800);
      chk_tlz("R10");
      for (int t = 0; t < 3; t++) begin
        acc(1'b1, 2, (t == 0) ? 64'd0 : (t == 1) ? 64'd1 : 64'd5);
        chk_tlz("R10");
        acc(1'b1, 1, 64'h0);  // hyper write alone leaves the request
        chk_tlz("R10");
        acc(1'b1, 1, {56'h0, 5'b0, h[1], 1'b0, h[0]} | 64'h800);
      end
    end
    acc(1'b1, 1, 64'h1); acc(1'b1, 2, 64'd0); chk_tlz("R10");
    acc(1'b1, 2, 64'd2); chk_tlz("R10");

    // R7: trap access at TL=0 refused, stacked data intact
    acc(1'b1, 2, 64'd0);
    for (int f = 0; f < 5; f++) acc(1'b1, 6 + f, 64'hDEAD);
    for (int f = 0; f < 5; f++) acc(1'b0, 6 + f, '0);
    idle_chk("R7");
    acc(1'b1, 2, 64'd1);
    for (int f = 0; f < 5; f++) acc(1'b0, 6 + f, '0);

    // R11: writes to unmapped numbers, then full sweep shows nothing moved
    for (int n = 18; n < 24; n++) acc(1'b1, n, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int n = 32; n < 64; n++) acc(1'b1, n, 64'hFFFF_FFFF_FFFF_FFFF);
    acc(1'b1, 40, 64'h1);
    idle_chk("R11");
    read_all();

    // R12: scratch registers independent
    for (int s = 0; s < 8; s++) acc(1'b1, 24 + s, pat(s, 5));
    for (int s = 7; s >= 0; s--) acc(1'b0, 24 + s, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule